// File: doc/BRIEF.md
# Decimal Adder-Subtractor with Digit Validation

This block adds or subtracts two packed multi-digit decimal (BCD) numbers in one combinational path. Each operand holds `DIGITS` four-bit digits. Digit 0 is the least significant and sits in bits [3:0]. Digit i sits in bits [4i+3:4i]. Addition runs through a ripple of single-digit decimal cells. Each cell forms a plain binary sum, then applies a plus-six correction whenever that sum leaves the 0..9 range.

Subtraction reuses the same chain. The second operand is replaced digit by digit with its nines complement. When the top digit produces a carry, the result is positive, and a second pass of the chain adds that carry back in as an end-around increment. When the top digit produces no carry, the result is negative, and the magnitude is the nines complement of the first-pass sum.

Before any of this, every input digit is checked. A digit code above 9 overrides the whole result with a fixed error pattern.

The block has no clock and no handshake. Its outputs follow its inputs after the combinational delay. The surrounding logic registers them where its own timing needs it.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With `sub_mode`=0 and all digits valid, `{carry_out, result}` equals the decimal value of A + B + `carry_in`. `carry_out` is the carry out of the top digit, worth 10^DIGITS, and `negative` is 0.
- R2: A single digit position gives the correct sum digit and carry for every digit total from 0 to 19, including 9+9+1 (digit 9, carry 1) and 9+0+1 (digit 0, carry 1).
- R3: A carry produced in one digit position propagates into the next more significant position, through every digit up to the top (for example 9999 + 0001 gives 0000 with `carry_out` 1).
- R4: With `sub_mode`=1, valid digits and A > B, `result` equals A − B, `negative` is 0 and `carry_out` is 0.
- R5: With `sub_mode`=1, valid digits and A < B, `result` equals B − A and `negative` is 1. `carry_out` is 0.
- R6: With `sub_mode`=1 and A = B, `result` is all zero digits and `negative` is 1.
- R7: With `sub_mode`=1, `carry_in` has no effect on any output.
- R8: If any digit of A or B has a code from 10 to 15, in any position and in either mode, `bad_digit` is 1, every `result` digit is 4'hF, and `carry_out` and `negative` are 0.
- R9: When every digit of A and B is in 0..9, `bad_digit` is 0 and every `result` digit is in 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4*DIGITS | First operand, packed BCD, digit 0 in bits [3:0] |
| op_b | input | 4*DIGITS | Second operand, packed BCD |
| sub_mode | input | 1 | 0 selects A + B, 1 selects A − B |
| carry_in | input | 1 | Decimal carry into digit 0 in add mode; ignored in subtract mode |
| result | output | 4*DIGITS | Packed BCD sum, or magnitude of the difference, or all 4'hF on error |
| carry_out | output | 1 | Carry out of the top digit in add mode; 0 otherwise |
| negative | output | 1 | 1 when a subtraction result is negative (or zero, see R6) |
| bad_digit | output | 1 | 1 when any input digit is not a valid decimal code |

## Verification
The datapath holds no state, so a fault in a cell, the complement stage or the end-around pass appears at the ports for the very input vector that exercises it.

A wrong correction term in a cell appears as a digit code above 9, or as a digit off by six. This shows only for digit totals at or above 10, so the stimulus pushes each position through totals from 10 to 19.

A broken end-around pass leaves positive differences one too small. This is visible on every subtraction with A > B. A faulty validity check appears either as arithmetic output where the error pattern is required, or as a false error flag on valid inputs.

// File: rtl/bcd_au_pkg.sv
package bcd_au_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_MAX = 4'd9;
  localparam digit_t DIGIT_ERR = 4'hF;
  localparam digit_t DIGIT_FIX = 4'd6;

  // decimal value of the lowest n digits of a packed word
  function automatic longint unsigned bcd_value(input logic [63:0] v, input int n);
    longint unsigned acc;
    acc = 0;
    for (int i = n - 1; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic longint unsigned dec_pow(input int n);
    longint unsigned p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_au_pkg::*;
(
  input  digit_t a_dig,
  input  digit_t b_dig,
  input  logic   c_in,
  output digit_t s_dig,
  output logic   c_out
);
  logic [DIGIT_W:0] bin_sum;
  digit_t           z;
  logic             k;
  logic             fix;

  always_comb begin
    bin_sum = {1'b0, a_dig} + {1'b0, b_dig} + {{DIGIT_W{1'b0}}, c_in};
    z       = bin_sum[DIGIT_W-1:0];
    k       = bin_sum[DIGIT_W];
    fix     = k | (z[3] & z[2]) | (z[3] & z[1]);
    s_dig   = z + (fix ? DIGIT_FIX : '0);
    c_out   = fix;
  end

  // R2: cell arithmetic over totals 0..19
  always_comb begin
    if (a_dig <= DIGIT_MAX && b_dig <= DIGIT_MAX) begin
      p_cell_total_r2: assert (int'(s_dig) + 10 * int'(c_out) ==
                               int'(a_dig) + int'(b_dig) + int'(c_in))
        else $error("cell total mismatch");
      p_cell_digit_r9: assert (s_dig <= DIGIT_MAX)
        else $error("cell digit not decimal");
    end
  end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
  import bcd_au_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_W
)(
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             cy_in,
  output logic [WIDTH-1:0] s_out,
  output logic             cy_out
);
  logic [DIGITS:0] cy;
  assign cy[0] = cy_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_cell
    bcd_digit_cell u_cell (
      .a_dig (x_in[g*DIGIT_W +: DIGIT_W]),
      .b_dig (y_in[g*DIGIT_W +: DIGIT_W]),
      .c_in  (cy[g]),
      .s_dig (s_out[g*DIGIT_W +: DIGIT_W]),
      .c_out (cy[g+1])
    );
  end

  assign cy_out = cy[DIGITS];
endmodule

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
  import bcd_au_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_W
)(
  input  logic [WIDTH-1:0] d_in,
  input  logic             en,
  output logic [WIDTH-1:0] d_out
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign d_out[g*DIGIT_W +: DIGIT_W] =
      en ? DIGIT_MAX - d_in[g*DIGIT_W +: DIGIT_W] : d_in[g*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
  import bcd_au_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_W
)(
  input  logic [WIDTH-1:0] word,
  output logic             any_bad
);
  logic [DIGITS-1:0] bad_vec;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign bad_vec[g] = word[g*DIGIT_W + 3] &
                        (word[g*DIGIT_W + 2] | word[g*DIGIT_W + 1]);
  end
  assign any_bad = |bad_vec;
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcd_au_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_W
)(
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             negative,
  output logic             bad_digit
);
  logic             bad_a, bad_b;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_top;
  logic [WIDTH-1:0] inc_sum;
  logic             inc_top;
  logic [WIDTH-1:0] neg_mag;
  logic             chain_cin;

  bcd_digit_check #(.DIGITS(DIGITS)) u_chk_a (.word(op_a), .any_bad(bad_a));
  bcd_digit_check #(.DIGITS(DIGITS)) u_chk_b (.word(op_b), .any_bad(bad_b));

  bcd_nines_comp #(.DIGITS(DIGITS)) u_comp_b (
    .d_in(op_b), .en(sub_mode), .d_out(b_eff));

  assign chain_cin = sub_mode ? 1'b0 : carry_in;

  // first pass: A + B or A + nines(B)
  bcd_digit_chain #(.DIGITS(DIGITS)) u_pass1 (
    .x_in(op_a), .y_in(b_eff), .cy_in(chain_cin),
    .s_out(raw_sum), .cy_out(raw_top));

  // second pass: end-around increment, separate hardware, no loop
  bcd_digit_chain #(.DIGITS(DIGITS)) u_pass2 (
    .x_in(raw_sum), .y_in('0), .cy_in(1'b1),
    .s_out(inc_sum), .cy_out(inc_top));

  bcd_nines_comp #(.DIGITS(DIGITS)) u_comp_r (
    .d_in(raw_sum), .en(1'b1), .d_out(neg_mag));

  always_comb begin
    bad_digit = bad_a | bad_b;
    if (bad_a | bad_b) begin
      result    = {DIGITS{DIGIT_ERR}};
      carry_out = 1'b0;
      negative  = 1'b0;
    end else if (!sub_mode) begin
      result    = raw_sum;
      carry_out = raw_top;
      negative  = 1'b0;
    end else if (raw_top) begin
      result    = inc_sum;
      carry_out = 1'b0;
      negative  = 1'b0;
    end else begin
      result    = neg_mag;
      carry_out = 1'b0;
      negative  = 1'b1;
    end
  end

  // value-level checks against decimal arithmetic
  always_comb begin
    if (!bad_digit && !sub_mode) begin
      p_add_value_r1: assert (bcd_value(64'(op_a), DIGITS) + bcd_value(64'(op_b), DIGITS) +
                              longint'(carry_in) ==
                              bcd_value(64'(result), DIGITS) +
                              (carry_out ? dec_pow(DIGITS) : 64'd0))
        else $error("sum value mismatch");
    end
    if (!bad_digit && sub_mode) begin
      p_sub_value_r4: assert (negative ||
                              bcd_value(64'(op_a), DIGITS) - bcd_value(64'(op_b), DIGITS) ==
                              bcd_value(64'(result), DIGITS))
        else $error("positive difference mismatch");
      p_sub_neg_r5: assert (!negative ||
                            bcd_value(64'(op_b), DIGITS) - bcd_value(64'(op_a), DIGITS) ==
                            bcd_value(64'(result), DIGITS))
        else $error("negative magnitude mismatch");
      p_sub_no_carry_r5: assert (!carry_out)
        else $error("carry in subtract mode");
      p_endaround_fits_r4: assert (!raw_top || !inc_top)
        else $error("end-around pass overflowed");
    end
    if (bad_digit) begin
      p_err_quiet_r8: assert (!carry_out && !negative)
        else $error("flags set during error");
    end
  end
endmodule

// File: tb/bcd_addsub_unit_test.sv
module bcd_addsub_unit_test;
  localparam int D = 4;
  localparam int W = 4 * D;
  localparam longint unsigned MODV = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic sub_mode, carry_in, carry_out, negative, bad_digit;

  int n_vec = 0;
  int n_bad = 0;

  bcd_addsub_unit #(.DIGITS(D)) uut (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .negative(negative),
    .bad_digit(bad_digit));

  function automatic longint unsigned to_int(input logic [W-1:0] v);
    longint unsigned acc = 0;
    for (int i = D - 1; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic logic [W-1:0] to_bcd(input longint unsigned n);
    logic [W-1:0] r;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  function automatic logic has_bad(input logic [W-1:0] v);
    for (int i = 0; i < D; i++) if (v[4*i +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sm, input logic ci);
    logic [W-1:0] e_res;
    logic e_cy, e_neg, e_bad;
    longint unsigned va, vb, s;
    @(negedge clk);
    op_a = a; op_b = b; sub_mode = sm; carry_in = ci;
    @(posedge clk);
    #1;
    e_bad = has_bad(a) | has_bad(b);
    va = to_int(a); vb = to_int(b);
    e_cy = 1'b0; e_neg = 1'b0;
    if (e_bad) e_res = {W{1'b1}};
    else if (!sm) begin
      s = va + vb + longint'(ci);
      e_cy = (s >= MODV);
      e_res = to_bcd(s % MODV);
    end else if (va > vb) e_res = to_bcd(va - vb);
    else begin
      e_res = to_bcd(vb - va);
      e_neg = 1'b1;
    end
    n_vec++;
    if (result !== e_res || carry_out !== e_cy || negative !== e_neg || bad_digit !== e_bad) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0d cin=%0d: got res=%h cy=%0d neg=%0d bad=%0d exp res=%h cy=%0d neg=%0d bad=%0d",
               tag, a, b, sm, ci, result, carry_out, negative, bad_digit,
               e_res, e_cy, e_neg, e_bad);
    end
  endtask

  function automatic logic [W-1:0] rand_valid();
    logic [W-1:0] r;
    for (int i = 0; i < D; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    op_a = '0; op_b = '0; sub_mode = 1'b0; carry_in = 1'b0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply("R1 reset-state zeros", '0, '0, 1'b0, 1'b0);
    // R2 single-digit totals 0..19
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        apply("R2 digit totals", W'(x), W'(y), 1'b0, 1'b1);
    apply("R2 nine+nine+one", 16'h0009, 16'h0009, 1'b0, 1'b1);
    apply("R3 ripple through all digits", 16'h9999, 16'h0001, 1'b0, 1'b0);
    apply("R3 ripple with carry_in", 16'h9999, 16'h0000, 1'b0, 1'b1);
    apply("R1 max sum", 16'h9999, 16'h9999, 1'b0, 1'b1);
    apply("R4 positive diff", 16'h5000, 16'h0001, 1'b1, 1'b0);
    apply("R4 positive diff borrow chain", 16'h1000, 16'h0999, 1'b1, 1'b0);
    apply("R5 negative diff", 16'h0001, 16'h9999, 1'b1, 1'b0);
    apply("R5 negative small", 16'h0123, 16'h0456, 1'b1, 1'b0);
    apply("R6 equal operands", 16'h4321, 16'h4321, 1'b1, 1'b0);
    apply("R6 equal zero", 16'h0000, 16'h0000, 1'b1, 1'b0);
    apply("R7 carry_in ignored positive", 16'h0800, 16'h0300, 1'b1, 1'b1);
    apply("R7 carry_in ignored negative", 16'h0300, 16'h0800, 1'b1, 1'b1);
    apply("R8 bad digit in A low", 16'h123A, 16'h0001, 1'b0, 1'b0);
    apply("R8 bad digit in B top", 16'h0001, 16'hF000, 1'b1, 1'b0);
    apply("R8 bad digit with carry", 16'h9999, 16'h9C99, 1'b0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      ra = rand_valid();
      rb = rand_valid();
      if (($urandom % 8) == 0) ra[4*($urandom % D) +: 4] = 4'(10 + $urandom % 6);
      if (($urandom % 8) == 0) rb[4*($urandom % D) +: 4] = 4'(10 + $urandom % 6);
      apply("R9 random mix", ra, rb, 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule